// File: doc/BRIEF.md
# Parallel Configuration Port Loader

This block is the master side of an 8-bit parallel configuration port on a programmable logic device. After a one-cycle start request it sequences a full load. It pulses the target's configuration reset, waits for the target's init line to be pulled low and then released, and selects the port for writing. After a settling delay it moves one byte per port clock from a valid/ready byte stream into the target. The load ends with a final check that the target reports it is configured.

Before each byte the loader samples the target's done line and its init line. A done already high ends the write loop early. An init line that is low means the target found a corrupt bitstream, and the load aborts at once. When the wait-check option is built in, the loader holds off after each byte until the target's wait line falls. Every wait has its own timeout, counted in system clock cycles. An abort returns all port pins to their idle levels and records a reason code and the byte offset. A second mode reads bytes back out of the port.

Top module: `cfg_port_loader`

## Requirements
- R1: Out of reset, the port pins sit at idle levels: target reset high, select high, write strobe high and port clock high. `s_ready`, `ok`, `fail` and `rb_valid` are 0.
- R2: A start request with `rd_mode`=0 drives target reset low for at least T_PROG cycles. Target reset stays low until the init input is seen low. If init is not seen low within T_INIT cycles after the minimum pulse, the loader aborts with code 1.
- R3: After target reset is released, the port clock stays high while the loader waits for init to go high. If init is not high within T_INIT cycles, the loader aborts with code 2.
- R4: Select and write strobe are both driven low at least T_SETTLE cycles before the first byte is clocked.
- R5: Each accepted stream byte is placed on `tgt_dout`, then the port clock goes low for exactly one cycle and back high. The target receives the stream bytes in stream order, one per port clock.
- R6: If done is high before a byte, no further byte is accepted and the loader goes to the final check.
- R7: If init is low before a byte, the loader aborts with code 3. `fail_offset` holds the number of bytes already clocked.
- R8: With the wait check built in, the loader holds after each byte until the wait input is low. If the wait input stays high for T_BUSY cycles, the loader aborts with code 4.
- R9: After `byte_count` bytes, select and write strobe return high. `ok` is raised only when done and init are both seen high within T_DONE cycles; otherwise the loader aborts with code 5.
- R10: An abort leaves all port pins idle. `ok`, `fail`, `fail_code` and `fail_offset` hold until the next accepted start. A start while a sequence runs is ignored. Codes: 1 init-assert timeout, 2 init-release timeout, 3 init low mid-load, 4 wait timeout, 5 done timeout.
- R11: A start with `rd_mode`=1 selects the port with the write strobe high and the port clock high. For each byte, the port clock goes low for one cycle and then high, and `tgt_din` is captured at the end of the high cycle. The captured byte appears on `rb_data` with a one-cycle `rb_valid` pulse. Afterwards select returns high, one more port clock cycle is issued, and `ok` is raised.
- R12: A `byte_count` of 0 clocks no byte in either mode, and the sequence still ends with `ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a sequence (taken only when idle) |
| rd_mode | input | 1 | Sampled with start: 0 load, 1 readback |
| byte_count | input | CNT_W | Number of bytes to write or read, sampled with start |
| s_data | input | DATA_W | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Loader takes the stream byte this cycle |
| tgt_rst_n | output | 1 | Target configuration reset, active low |
| tgt_init_n_i | input | 1 | Target init/error line, low while clearing or on error |
| tgt_done_i | input | 1 | Target configured indication |
| tgt_wait_i | input | 1 | Target not ready for the next byte |
| tgt_sel_n | output | 1 | Port select, active low |
| tgt_wr_n | output | 1 | Direction strobe, low for write |
| tgt_clk | output | 1 | Port clock, target samples on its rising edge |
| tgt_dout | output | DATA_W | Byte driven to the target |
| tgt_doe | output | 1 | Output enable for tgt_dout |
| tgt_din | input | DATA_W | Byte returned by the target in readback |
| rb_data | output | DATA_W | Captured readback byte |
| rb_valid | output | 1 | One-cycle strobe for rb_data |
| ok | output | 1 | Sticky success flag |
| fail | output | 1 | Sticky failure flag |
| fail_code | output | 3 | Abort reason, 1..5 |
| fail_offset | output | CNT_W | Bytes clocked before the abort |

## Verification
The bench sweeps load lengths against wait-line lengths and checks that every byte reaches the target once and in order. A design that clocked a byte twice or held the clock low for two cycles would change the byte count or the low-run length the target model records. Each abort path is forced by a target model that withholds one handshake. A loader that mixed up the code order or kept driving the port after an abort would show a wrong code or a non-idle pin. The init-error case is injected both before the first byte and mid-stream, so an off-by-one offset shows. Early done, a zero-length load, a readback with its trailing clock, and a start issued mid-load (which must not disturb the load) are run as separate cases.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_PULSE, S_INITLO, S_INITHI, S_SETTLE, S_CHECK, S_CLKLO, S_CLKHI,
      S_BWAIT, S_FINISH, S_RB_SEL, S_RB_LO, S_RB_HI, S_RB_ELO, S_RB_EHI
   } ld_state_t;

   typedef enum logic [2:0] {
      E_NONE         = 3'd0,
      E_INIT_ASSERT  = 3'd1,
      E_INIT_RELEASE = 3'd2,
      E_CRC          = 3'd3,
      E_WAIT         = 3'd4,
      E_DONE         = 3'd5
   } ld_err_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfg_ld_timer.sv
module cfg_ld_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] elapsed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                elapsed <= '0;
      else if (clr)              elapsed <= '0;
      else if (elapsed != '1)    elapsed <= elapsed + W'(1);
   end
endmodule

// File: rtl/cfg_ld_count.sv
module cfg_ld_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] value
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     value <= '0;
      else if (clr)   value <= '0;
      else if (inc)   value <= value + W'(1);
   end
endmodule

// File: rtl/cfg_port_loader.sv
module cfg_port_loader
   import cfg_ld_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 24,
   parameter bit BUSY_CHECK = 1'b1,
   parameter int T_PROG     = 16,
   parameter int T_INIT     = 25_000_000,
   parameter int T_SETTLE   = 500_000,
   parameter int T_BUSY     = 250_000,
   parameter int T_DONE     = 10_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_mode,
   input  logic [CNT_W-1:0]  byte_count,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_valid,
   output logic              s_ready,
   output logic              tgt_rst_n,
   input  logic              tgt_init_n_i,
   input  logic              tgt_done_i,
   input  logic              tgt_wait_i,
   output logic              tgt_sel_n,
   output logic              tgt_wr_n,
   output logic              tgt_clk,
   output logic [DATA_W-1:0] tgt_dout,
   output logic              tgt_doe,
   input  logic [DATA_W-1:0] tgt_din,
   output logic [DATA_W-1:0] rb_data,
   output logic              rb_valid,
   output logic              ok,
   output logic              fail,
   output logic [2:0]        fail_code,
   output logic [CNT_W-1:0]  fail_offset
);
   localparam int TMAX  = max_of(max_of(max_of(T_PROG, T_INIT), max_of(T_SETTLE, T_BUSY)), T_DONE);
   localparam int TMR_W = $clog2(TMAX + 1);
   localparam logic [TMR_W-1:0] PROG_END   = TMR_W'(T_PROG - 1);
   localparam logic [TMR_W-1:0] INIT_END   = TMR_W'(T_INIT - 1);
   localparam logic [TMR_W-1:0] SETTLE_END = TMR_W'(T_SETTLE - 1);
   localparam logic [TMR_W-1:0] BUSY_END   = TMR_W'(T_BUSY - 1);
   localparam logic [TMR_W-1:0] DONE_END   = TMR_W'(T_DONE - 1);

   if (DATA_W < 1)  begin : g_bad_width $error("DATA_W must be at least 1"); end
   if (CNT_W < 1)   begin : g_bad_cnt   $error("CNT_W must be at least 1"); end
   if (T_PROG < 2)  begin : g_bad_prog  $error("T_PROG must be at least 2"); end
   if (T_INIT < 1 || T_SETTLE < 1 || T_BUSY < 1 || T_DONE < 1)
      begin : g_bad_tmo $error("timeouts must be at least 1 cycle"); end

   ld_state_t          st, nxt, post_clk;
   ld_err_t            abort_code;
   logic               finish_ok, accept, start_go, tmr_clr, last;
   logic [TMR_W-1:0]   tmr;
   logic [CNT_W-1:0]   cnt_q, lim_q;

   // Which state follows each byte's rising clock edge is a build option
   if (BUSY_CHECK) begin : g_wait_on
      assign post_clk = S_BWAIT;
   end else begin : g_wait_off
      assign post_clk = S_CHECK;
   end

   assign start_go = (st == S_IDLE) && start;
   assign last     = (cnt_q == lim_q);
   assign s_ready  = (st == S_CHECK) && !tgt_done_i && tgt_init_n_i && !last;
   assign accept   = s_ready && s_valid;
   assign tmr_clr  = (nxt != st);

   cfg_ld_timer #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .elapsed(tmr)
   );

   cfg_ld_count #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(start_go),
      .inc(accept || (st == S_RB_HI)), .value(cnt_q)
   );

   always_comb begin
      nxt        = st;
      abort_code = E_NONE;
      finish_ok  = 1'b0;
      unique case (st)
         S_IDLE:   if (start) nxt = rd_mode ? S_RB_SEL : S_PULSE;
         S_PULSE:  if (tmr == PROG_END) nxt = S_INITLO;
         S_INITLO: if (!tgt_init_n_i) nxt = S_INITHI;
                   else if (tmr == INIT_END) abort_code = E_INIT_ASSERT;
         S_INITHI: if (tgt_init_n_i) nxt = S_SETTLE;
                   else if (tmr == INIT_END) abort_code = E_INIT_RELEASE;
         S_SETTLE: if (tmr == SETTLE_END) nxt = S_CHECK;
         S_CHECK:  if (tgt_done_i) nxt = S_FINISH;
                   else if (!tgt_init_n_i) abort_code = E_CRC;
                   else if (last) nxt = S_FINISH;
                   else if (s_valid) nxt = S_CLKLO;
         S_CLKLO:  nxt = S_CLKHI;
         S_CLKHI:  nxt = post_clk;
         S_BWAIT:  if (!tgt_wait_i) nxt = S_CHECK;
                   else if (tmr == BUSY_END) abort_code = E_WAIT;
         S_FINISH: if (tgt_done_i && tgt_init_n_i) begin
                      finish_ok = 1'b1;
                      nxt       = S_IDLE;
                   end else if (tmr == DONE_END) abort_code = E_DONE;
         S_RB_SEL: nxt = last ? S_RB_ELO : S_RB_LO;
         S_RB_LO:  nxt = S_RB_HI;
         S_RB_HI:  nxt = ((cnt_q + CNT_W'(1)) == lim_q) ? S_RB_ELO : S_RB_LO;
         S_RB_ELO: nxt = S_RB_EHI;
         S_RB_EHI: begin finish_ok = 1'b1; nxt = S_IDLE; end
         default:  nxt = S_IDLE;
      endcase
      if (abort_code != E_NONE) nxt = S_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         lim_q       <= '0;
         tgt_dout    <= '0;
         rb_data     <= '0;
         rb_valid    <= 1'b0;
         ok          <= 1'b0;
         fail        <= 1'b0;
         fail_code   <= 3'd0;
         fail_offset <= '0;
      end else begin
         st       <= nxt;
         rb_valid <= (st == S_RB_HI);
         if (st == S_RB_HI) rb_data  <= tgt_din;
         if (accept)        tgt_dout <= s_data;
         if (start_go) begin
            lim_q       <= byte_count;
            ok          <= 1'b0;
            fail        <= 1'b0;
            fail_code   <= 3'd0;
            fail_offset <= '0;
         end
         if (finish_ok) ok <= 1'b1;
         if (abort_code != E_NONE) begin
            fail        <= 1'b1;
            fail_code   <= abort_code;
            fail_offset <= cnt_q;
         end
      end
   end

   assign tgt_rst_n = !(st inside {S_PULSE, S_INITLO});
   assign tgt_clk   = !(st inside {S_CLKLO, S_RB_LO, S_RB_ELO});
   assign tgt_wr_n  = !(st inside {S_SETTLE, S_CHECK, S_CLKLO, S_CLKHI, S_BWAIT});
   assign tgt_sel_n = tgt_wr_n && !(st inside {S_RB_SEL, S_RB_LO, S_RB_HI});
   assign tgt_doe   = !tgt_wr_n;

   // R2
   prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tgt_rst_n) |=> !tgt_rst_n);

   // R5
   byte_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready && s_valid) |=> !tgt_clk ##1 tgt_clk);

   // R9
   done_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ok) && $past(st == S_FINISH)) |-> $past(tgt_done_i && tgt_init_n_i));

   // R9
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok && fail));

   // R10
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> (tgt_rst_n && tgt_sel_n && tgt_wr_n && tgt_clk && fail_code != 3'd0));

   // R7
   crc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fail) && fail_code == 3'd3) |-> $past(!tgt_init_n_i));

   // R11
   rb_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rb_valid |-> (!tgt_sel_n && tgt_wr_n) || $past(st == S_RB_HI));

endmodule

// File: tb/cfg_port_loader_tb.sv
module cfg_port_loader_tb;
   localparam int DW = 8, CW = 8;
   localparam int TP = 4, TI = 20, TS = 5, TB = 6, TD = 15;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, rd_mode = 1'b0;
   logic [CW-1:0] byte_count = '0;
   logic [DW-1:0] s_data;
   logic s_valid = 1'b1, s_ready;
   logic tgt_rst_n, tgt_sel_n, tgt_wr_n, tgt_clk, tgt_doe, rb_valid, ok, fail;
   logic init_n_o = 1'b1, done_o = 1'b0, wait_o = 1'b0;
   logic [DW-1:0] tgt_dout, tgt_din, rb_data;
   logic [2:0] fail_code;
   logic [CW-1:0] fail_offset;

   int total = 0, bad = 0, cyc = 0, sent = 0, base = 0;
   int c_busy = 0, c_done_at = 0, c_err_at = -1;
   bit c_nlo = 0, c_nhi = 0, c_stuck = 0, c_dnever = 0;
   int lo_cnt = 0, hi_cnt = 0, rx_cnt = 0, rd_cnt = 0, busy_left = 0, pre_cnt = 0;
   int low_run = 0, low_max = 0, ext_rise = 0, prog_lo = 0, rb_n = 0;
   bit err_l = 0, prev_clk = 1, clk_viol = 0;
   logic [7:0] rx_mem [0:63];
   logic [7:0] rb_mem [0:63];

   always #10 clk = ~clk;

   function automatic logic [7:0] pat_w(input int i);
      return 8'((i * 37 + 5) & 255);
   endfunction
   function automatic logic [7:0] pat_r(input int i);
      return 8'(((i * 11) ^ 165) & 255);
   endfunction

   assign s_data  = pat_w(sent);
   assign tgt_din = pat_r(rd_cnt);

   cfg_port_loader #(.DATA_W(DW), .CNT_W(CW), .BUSY_CHECK(1'b1), .T_PROG(TP),
                     .T_INIT(TI), .T_SETTLE(TS), .T_BUSY(TB), .T_DONE(TD)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode), .byte_count(byte_count),
      .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .tgt_rst_n(tgt_rst_n),
      .tgt_init_n_i(init_n_o), .tgt_done_i(done_o), .tgt_wait_i(wait_o),
      .tgt_sel_n(tgt_sel_n), .tgt_wr_n(tgt_wr_n), .tgt_clk(tgt_clk), .tgt_dout(tgt_dout),
      .tgt_doe(tgt_doe), .tgt_din(tgt_din), .rb_data(rb_data), .rb_valid(rb_valid),
      .ok(ok), .fail(fail), .fail_code(fail_code), .fail_offset(fail_offset));

   always @(posedge clk) if (s_valid && s_ready) sent <= sent + 1;

   // target model, updates away from the active edge
   always @(negedge clk) begin
      if (start) begin low_max = 0; rd_cnt = 0; ext_rise = 0; clk_viol = 0; rb_n = 0; end
      if (rb_valid) begin rb_mem[rb_n % 64] = rb_data; rb_n++; end
      if (!tgt_rst_n) begin
         prog_lo++; lo_cnt++; hi_cnt = 0; rx_cnt = 0; err_l = 0; done_o = 0;
         busy_left = 0; pre_cnt = 0;
         if (lo_cnt >= 2 && !c_nlo) init_n_o = 0;
      end else begin
         lo_cnt = 0;
         if (!init_n_o && !err_l) begin
            if (!tgt_clk) clk_viol = 1;
            hi_cnt++;
            if (hi_cnt >= 3 && !c_nhi) init_n_o = 1;
         end
         if (tgt_clk && !prev_clk) begin
            if (!tgt_sel_n && !tgt_wr_n) begin
               rx_mem[rx_cnt % 64] = tgt_dout; rx_cnt++; busy_left = c_busy;
            end else if (!tgt_sel_n) rd_cnt++;
            else ext_rise++;
         end
         if (!tgt_sel_n && !tgt_wr_n && rx_cnt == 0) pre_cnt++;
         if (!tgt_sel_n && !tgt_wr_n && rx_cnt == c_err_at && !err_l) begin
            init_n_o = 0; err_l = 1;
         end
         if (init_n_o && !c_dnever && !err_l && rx_cnt >= c_done_at) done_o = 1;
      end
      wait_o = c_stuck ? (rx_cnt > 0) : (busy_left > 0);
      if (busy_left > 0) busy_left--;
      if (!tgt_clk) low_run++; else low_run = 0;
      if (low_run > low_max) low_max = low_run;
      prev_clk = tgt_clk;
   end

   task automatic chk(input bit c, input string tag, input int act, input int exp);
      total++;
      if (!c) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic kick(input bit rd, input int n);
      @(posedge clk); #2;
      base = sent; rd_mode = rd; byte_count = CW'(n); start = 1'b1; prog_lo = 0;
      @(posedge clk); #2;
      start = 1'b0;
   endtask

   task automatic wait_end();
      do @(negedge clk); while (!(ok || fail));
   endtask

   task automatic setup(input int bl, input int da, input int ea, input bit nlo,
                        input bit nhi, input bit st, input bit dn);
      c_busy = bl; c_done_at = da; c_err_at = ea; c_nlo = nlo; c_nhi = nhi;
      c_stuck = st; c_dnever = dn;
   endtask

   task automatic check_idle(input string tag);
      chk(tgt_rst_n && tgt_sel_n && tgt_wr_n && tgt_clk, tag,
          {tgt_rst_n, tgt_sel_n, tgt_wr_n, tgt_clk}, 15);
   endtask

   task automatic check_bytes(input string tag, input int n);
      int mism = 0;
      for (int j = 0; j < n; j++) if (rx_mem[j] !== pat_w(base + j)) mism++;
      chk(mism == 0, tag, mism, 0);
   endtask

   task automatic check_fail(input string tag, input int code);
      chk(fail && !ok, {tag, " fail flag"}, fail, 1);
      chk(fail_code == 3'(code), {tag, " code"}, fail_code, code);
      check_idle({tag, " idle pins after abort"});
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_idle("R1 idle pins");
      chk(!s_ready && !ok && !fail && !rb_valid, "R1 flags", {s_ready, ok, fail, rb_valid}, 0);

      // R2 R3 R4 R5 R8 R9: sweep of lengths and wait-line lengths
      for (int n = 1; n <= 6; n++) begin
         for (int bl = 0; bl <= 2; bl++) begin
            setup(bl, n, -1, 0, 0, 0, 0);
            kick(1'b0, n); wait_end();
            chk(ok && !fail, "R9 ok after load", ok, 1);
            chk(rx_cnt == n, "R5 bytes received", rx_cnt, n);
            check_bytes("R5 byte order", n);
            chk(prog_lo >= TP, "R2 reset pulse width", prog_lo, TP);
            chk(pre_cnt >= TS, "R4 settle before first byte", pre_cnt, TS);
            chk(low_max == 1, "R5 clock low one cycle", low_max, 1);
            chk(!clk_viol, "R3 clock high during init release", clk_viol, 0);
            check_idle("R9 pins idle after load");
         end
      end

      // R2 init never asserted
      setup(0, 3, -1, 1, 0, 0, 0);
      kick(1'b0, 3); wait_end();
      check_fail("R2 init assert timeout", 1);
      // R3 init never released
      setup(0, 3, -1, 0, 1, 0, 0);
      kick(1'b0, 3); wait_end();
      check_fail("R3 init release timeout", 2);
      // R7 error before first byte and mid-stream
      for (int k = 0; k <= 2; k += 2) begin
         setup(1, 6, k, 0, 0, 0, 0);
         kick(1'b0, 6); wait_end();
         check_fail("R7 init low mid-load", 3);
         chk(fail_offset == CW'(k), "R7 fail offset", fail_offset, k);
         chk(rx_cnt == k, "R7 no byte after error", rx_cnt, k);
      end
      // R8 wait stuck
      setup(0, 4, -1, 0, 0, 1, 0);
      kick(1'b0, 4); wait_end();
      check_fail("R8 wait timeout", 4);
      chk(rx_cnt == 1, "R8 held after first byte", rx_cnt, 1);
      // R9 done never
      setup(0, 4, -1, 0, 0, 0, 1);
      kick(1'b0, 4); wait_end();
      check_fail("R9 done timeout", 5);
      chk(rx_cnt == 4, "R9 all bytes before check", rx_cnt, 4);
      // R10 sticky until next start
      repeat (10) @(negedge clk);
      chk(fail && fail_code == 3'd5, "R10 sticky code", fail_code, 5);
      // R6 early done
      setup(0, 3, -1, 0, 0, 0, 0);
      kick(1'b0, 6); wait_end();
      chk(ok && !fail, "R6 early done ok", ok, 1);
      chk(rx_cnt == 3, "R6 stopped early", rx_cnt, 3);
      chk(sent - base == 3, "R6 stream not consumed", sent - base, 3);
      // R12 zero-length load
      setup(0, 0, -1, 0, 0, 0, 0);
      kick(1'b0, 0); wait_end();
      chk(ok && rx_cnt == 0, "R12 zero load", rx_cnt, 0);
      // R10 start ignored mid-load
      setup(1, 5, -1, 0, 0, 0, 0);
      kick(1'b0, 5);
      repeat (20) @(posedge clk);
      #2 rd_mode = 1'b1; byte_count = '0; start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      wait_end();
      chk(ok && rx_cnt == 5, "R10 start ignored while running", rx_cnt, 5);
      check_bytes("R10 bytes intact", 5);
      // R11 readback
      kick(1'b1, 4); wait_end();
      chk(ok && !fail, "R11 readback ok", ok, 1);
      chk(rb_n == 4, "R11 bytes captured", rb_n, 4);
      begin
         int mism = 0;
         for (int j = 0; j < 4; j++) if (rb_mem[j] !== pat_r(j + 1)) mism++;
         chk(mism == 0, "R11 readback data", mism, 0);
      end
      chk(ext_rise == 1, "R11 trailing clock", ext_rise, 1);
      chk(low_max == 1, "R11 clock low one cycle", low_max, 1);
      check_idle("R11 pins idle after readback");
      // R12 zero-length readback
      kick(1'b1, 0); wait_end();
      chk(ok && rb_n == 0, "R12 zero readback", rb_n, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule